// File: doc/BRIEF.md
# Home-node directory coherence controller

This block is the home directory for a small, fixed set of cache blocks shared by a group of requesting caches. For every block it keeps a state (Invalid, Shared or Modified) and a bit vector with one bit per requestor port. Requestors ask for read permission (GetS) or write permission (GetM) on their own valid/ready request channel. The directory answers on one response channel and sends invalidations or forwarded reads on one forward channel. Both output channels are point-to-point valid/ready links.

On a write request the directory does not wait for the invalidation acknowledgements. It tells the requestor at once how many acknowledgements to expect. It then sends one invalidation to each other holder of the block, and each holder acknowledges straight to the requestor. The requestor may write once it holds the count and has received that many acknowledgements. A read request on a block owned by another port is forwarded to that owner, which supplies the requestor itself. In that case the directory sends no response, and both caches end as sharers.

The directory writes a block's final state when it accepts the request. Until all forwards of a transaction have left, new requests to that block wait. Requests to other blocks that need only a single reply are still served.

Top module: `coh_directory`

## Requirements
- R1: After reset every block is Invalid with an empty sharer vector, and no response or forward is valid. The first GetM to any block is therefore answered with an ack count of 0.
- R2: A GetS to a block in Invalid or Shared gets a response with rspIsM=0 and rspAcks=0 to the requestor. The requestor is added to the sharers and the block becomes Shared.
- R3: A GetS to a block held Modified by another port gets no response. Instead one forward with fwdShare=1 goes to the owner, with fwdReq set to the requestor. The block becomes Shared with sharers {owner, requestor}.
- R4: A GetM gets a response with rspIsM=1, where rspAcks is the number of sharers other than the requestor. The block then becomes Modified with the requestor as the only sharer.
- R5: For a GetM, one forward with fwdShare=0 goes to each other sharer, lowest port index first and one per forward handshake. Each forward has fwdReq set to the requestor and fwdBlk set to the block.
- R6: If the sharer vector is empty or holds only the requestor, a GetM gets rspAcks=0 and no invalidation is sent.
- R7: For each requestor and block, the number of invalidations naming that requestor equals the ack count announced to it.
- R8: While forwards for a block are still pending, no request to that block is accepted. A request to another block that needs no forward can still be accepted.
- R9: A request is accepted only while the response slot is empty and, if it needs forwards, only while no forwards are pending. At most one request is accepted per cycle, and the lowest-index eligible port wins.
- R10: A valid response or forward not taken by its ready holds all its fields unchanged.
- R11: A GetS from the current owner of a Modified block gets a response with rspIsM=0 and rspAcks=0. The block becomes Shared with the owner as sole sharer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N_PORTS | Request valid, one bit per port |
| reqReady | output | N_PORTS | Request accepted, one bit per port |
| reqIsM | input | N_PORTS | 1 = GetM, 0 = GetS, per port |
| reqBlk | input | N_PORTS*BW | Block index per port, port p at bits p*BW |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response taken |
| rspDst | output | IDW | Port the response goes to |
| rspIsM | output | 1 | 1 = write grant, 0 = read grant |
| rspAcks | output | IDW | Invalidation acks the requestor must collect |
| rspBlk | output | BW | Block of the response |
| fwdValid | output | 1 | Forward valid |
| fwdReady | input | 1 | Forward taken |
| fwdDst | output | IDW | Port the forward goes to |
| fwdShare | output | 1 | 1 = forwarded read to owner, 0 = invalidation |
| fwdReq | output | IDW | Requestor the target must answer |
| fwdBlk | output | BW | Block of the forward |

## Verification
A wrong state bit or sharer bit stays hidden until the next request to that block. That request then shows it as a wrong ack count, an extra or missing invalidation, or a forwarded read where a plain grant was due. A fault in the stall logic shows in the same cycle as a ready on the busy block. The bench compares all outputs against a behavioural model in every cycle, so a divergence is reported at its first visible cycle. It also counts invalidations at each requestor against the announced count, which catches message faults that a per-cycle view of the directory alone would miss.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    DIR_I = 2'd0,
    DIR_S = 2'd1,
    DIR_M = 2'd2
  } dirState_t;

  typedef struct packed {
    logic accept;
    logic popRsp;
    logic popFwd;
  } dirStrobes_t;
endpackage

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_BLOCKS = 8,
  localparam int IDW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic [N_PORTS-1:0]    reqValid,
  input  logic [N_PORTS*BW-1:0] reqBlk,
  input  logic [N_PORTS-1:0]    needFwd,
  input  logic                  fwdBusy,
  input  logic [BW-1:0]         fwdBlk,
  input  logic                  rspFull,
  input  logic                  rspReady,
  input  logic                  fwdReady,
  output logic [N_PORTS-1:0]    reqReady,
  output logic [IDW-1:0]        winner,
  output dirStrobes_t           strobes
);
  logic [N_PORTS-1:0] eligible;
  logic anyEligible;

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_elig
    logic sameBusyBlk;
    assign sameBusyBlk = fwdBusy && (reqBlk[gp*BW +: BW] == fwdBlk);
    assign eligible[gp] = reqValid[gp] && !rspFull && !sameBusyBlk &&
                          !(needFwd[gp] && fwdBusy);
  end

  always_comb begin
    winner = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (eligible[i]) winner = IDW'(i);
    end
  end

  assign anyEligible = |eligible;

  always_comb begin
    reqReady = '0;
    if (anyEligible) reqReady[winner] = 1'b1;
  end

  assign strobes.accept = anyEligible;
  assign strobes.popRsp = rspFull && rspReady;
  assign strobes.popFwd = fwdBusy && fwdReady;
endmodule

// File: rtl/coh_dir_datapath.sv
module coh_dir_datapath
  import coh_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_BLOCKS = 8,
  localparam int IDW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dirStrobes_t           strobes,
  input  logic [IDW-1:0]        winner,
  input  logic [N_PORTS-1:0]    reqIsM,
  input  logic [N_PORTS*BW-1:0] reqBlk,
  output logic [N_PORTS-1:0]    needFwd,
  output logic                  fwdBusy,
  output logic                  rspFull,
  output logic                  rspValid,
  output logic [IDW-1:0]        rspDst,
  output logic                  rspIsM,
  output logic [IDW-1:0]        rspAcks,
  output logic [BW-1:0]         rspBlk,
  output logic                  fwdValid,
  output logic [IDW-1:0]        fwdDst,
  output logic                  fwdShare,
  output logic [IDW-1:0]        fwdReq,
  output logic [BW-1:0]         fwdBlk
);
  dirState_t          dirSt [N_BLOCKS];
  logic [N_PORTS-1:0] dirSh [N_BLOCKS];

  logic [N_PORTS-1:0] others [N_PORTS];
  logic [IDW-1:0]     ackCnt [N_PORTS];
  logic [N_PORTS-1:0] fwdMask;

  function automatic logic [IDW-1:0] countBits(input logic [N_PORTS-1:0] v);
    logic [IDW-1:0] c;
    c = '0;
    for (int i = 0; i < N_PORTS; i++) c = c + IDW'(v[i]);
    return c;
  endfunction

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_look
    logic [BW-1:0] blkIdx;
    logic [N_PORTS-1:0] selfBit;
    assign blkIdx = reqBlk[gp*BW +: BW];
    assign selfBit = N_PORTS'(1) << gp;
    assign others[gp] = dirSh[blkIdx] & ~selfBit;
    assign needFwd[gp] = (|others[gp]) && (reqIsM[gp] || dirSt[blkIdx] == DIR_M);
    assign ackCnt[gp] = countBits(others[gp]);
  end

  logic [BW-1:0]      winBlk;
  logic               winIsM;
  logic               winNeedFwd;
  logic [N_PORTS-1:0] winSelf;
  logic [N_PORTS-1:0] winOthers;

  assign winBlk = reqBlk[winner*BW +: BW];
  assign winIsM = reqIsM[winner];
  assign winNeedFwd = needFwd[winner];
  assign winSelf = N_PORTS'(1) << winner;
  assign winOthers = others[winner];

  always_comb begin
    fwdDst = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (fwdMask[i]) fwdDst = IDW'(i);
    end
  end

  assign fwdValid = |fwdMask;
  assign fwdBusy = fwdValid;
  assign rspFull = rspValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < N_BLOCKS; b++) begin
        dirSt[b] <= DIR_I;
        dirSh[b] <= '0;
      end
      fwdMask  <= '0;
      fwdShare <= 1'b0;
      fwdReq   <= '0;
      fwdBlk   <= '0;
      rspValid <= 1'b0;
      rspDst   <= '0;
      rspIsM   <= 1'b0;
      rspAcks  <= '0;
      rspBlk   <= '0;
    end else begin
      if (strobes.popFwd) fwdMask <= fwdMask & ~(N_PORTS'(1) << fwdDst);
      if (strobes.popRsp) rspValid <= 1'b0;
      if (strobes.accept) begin
        if (winNeedFwd) begin
          fwdMask  <= winOthers;
          fwdShare <= !winIsM;
          fwdReq   <= winner;
          fwdBlk   <= winBlk;
        end
        if (winIsM || !winNeedFwd) begin
          rspValid <= 1'b1;
          rspDst   <= winner;
          rspIsM   <= winIsM;
          rspAcks  <= winIsM ? ackCnt[winner] : '0;
          rspBlk   <= winBlk;
        end
        if (winIsM) begin
          dirSt[winBlk] <= DIR_M;
          dirSh[winBlk] <= winSelf;
        end else begin
          dirSt[winBlk] <= DIR_S;
          dirSh[winBlk] <= dirSh[winBlk] | winSelf;
        end
      end
    end
  end
endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import coh_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_BLOCKS = 8,
  localparam int IDW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N_PORTS-1:0]    reqValid,
  output logic [N_PORTS-1:0]    reqReady,
  input  logic [N_PORTS-1:0]    reqIsM,
  input  logic [N_PORTS*BW-1:0] reqBlk,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic [IDW-1:0]        rspDst,
  output logic                  rspIsM,
  output logic [IDW-1:0]        rspAcks,
  output logic [BW-1:0]         rspBlk,
  output logic                  fwdValid,
  input  logic                  fwdReady,
  output logic [IDW-1:0]        fwdDst,
  output logic                  fwdShare,
  output logic [IDW-1:0]        fwdReq,
  output logic [BW-1:0]         fwdBlk
);
  dirStrobes_t        strobes;
  logic [IDW-1:0]     winner;
  logic [N_PORTS-1:0] needFwd;
  logic               fwdBusy;
  logic               rspFull;

  coh_dir_ctrl #(.N_PORTS(N_PORTS), .N_BLOCKS(N_BLOCKS)) u_ctrl (
    .reqValid(reqValid), .reqBlk(reqBlk), .needFwd(needFwd),
    .fwdBusy(fwdBusy), .fwdBlk(fwdBlk), .rspFull(rspFull),
    .rspReady(rspReady), .fwdReady(fwdReady), .reqReady(reqReady),
    .winner(winner), .strobes(strobes)
  );

  coh_dir_datapath #(.N_PORTS(N_PORTS), .N_BLOCKS(N_BLOCKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winner(winner),
    .reqIsM(reqIsM), .reqBlk(reqBlk), .needFwd(needFwd),
    .fwdBusy(fwdBusy), .rspFull(rspFull), .rspValid(rspValid),
    .rspDst(rspDst), .rspIsM(rspIsM), .rspAcks(rspAcks), .rspBlk(rspBlk),
    .fwdValid(fwdValid), .fwdDst(fwdDst), .fwdShare(fwdShare),
    .fwdReq(fwdReq), .fwdBlk(fwdBlk)
  );
endmodule

// File: rtl/coh_directory_chk.sv
module coh_directory_chk #(
  parameter int N_PORTS = 4,
  parameter int N_BLOCKS = 8,
  localparam int IDW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int BW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [N_PORTS-1:0]    reqValid,
  input logic [N_PORTS-1:0]    reqReady,
  input logic [N_PORTS-1:0]    reqIsM,
  input logic [N_PORTS*BW-1:0] reqBlk,
  input logic                  rspValid,
  input logic                  rspReady,
  input logic [IDW-1:0]        rspDst,
  input logic                  rspIsM,
  input logic [IDW-1:0]        rspAcks,
  input logic [BW-1:0]         rspBlk,
  input logic                  fwdValid,
  input logic                  fwdReady,
  input logic [IDW-1:0]        fwdDst,
  input logic                  fwdShare,
  input logic [IDW-1:0]        fwdReq,
  input logic [BW-1:0]         fwdBlk
);
  assert_one_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  assert_ready_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady & ~reqValid) == '0);

  assert_rsp_slot_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (reqReady == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspDst) && $stable(rspIsM) &&
                                 $stable(rspAcks) && $stable(rspBlk)));

  assert_fwd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> (fwdValid && $stable(fwdDst) && $stable(fwdShare) &&
                                 $stable(fwdReq) && $stable(fwdBlk)));

  assert_read_grant_no_acks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspIsM) |-> (rspAcks == '0));

  assert_fwd_read_not_self_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdShare) |-> (fwdDst != fwdReq));

  assert_inv_not_self_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdShare) |-> (fwdDst != fwdReq));

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_stall
    assert_busy_block_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
      (fwdValid && reqReady[gp]) |-> (reqBlk[gp*BW +: BW] != fwdBlk));
  end
endmodule

bind coh_directory coh_directory_chk #(.N_PORTS(N_PORTS), .N_BLOCKS(N_BLOCKS)) u_chk (.*);

// File: tb/coh_directory_tb.sv
module coh_directory_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int IDW = 2;
  localparam int BW = 3;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] reqValid = '0;
  logic [NP-1:0] reqReady;
  logic [NP-1:0] reqIsM = '0;
  logic [NP*BW-1:0] reqBlk = '0;
  logic rspValid, rspIsM, fwdValid, fwdShare;
  logic rspReady = 1'b0;
  logic fwdReady = 1'b0;
  logic [IDW-1:0] rspDst, rspAcks, fwdDst, fwdReq;
  logic [BW-1:0] rspBlk, fwdBlk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coh_directory #(.N_PORTS(NP), .N_BLOCKS(NB)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsM(reqIsM), .reqBlk(reqBlk), .rspValid(rspValid), .rspReady(rspReady),
    .rspDst(rspDst), .rspIsM(rspIsM), .rspAcks(rspAcks), .rspBlk(rspBlk),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdDst(fwdDst),
    .fwdShare(fwdShare), .fwdReq(fwdReq), .fwdBlk(fwdBlk)
  );

  int checks = 0;
  int errors = 0;

  // reference model: 0 = Invalid, 1 = Shared, 2 = Modified
  int mSt [NB];
  bit [NP-1:0] mSh [NB];
  bit mRspV;
  int mRspDst, mRspM, mRspAcks, mRspBlk;
  string mRspTag;
  bit [NP-1:0] mFwdMask;
  int mFwdShare, mFwdReq, mFwdBlk;
  // requestor-side ack tracking
  int ann [NP][NB];
  int got [NP][NB];
  int outInv [NP][NB];
  bit granted [NP][NB];

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic int popc(input bit [NP-1:0] v);
    int c = 0;
    for (int i = 0; i < NP; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int lowBit(input bit [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prevWin;
    bit prevHeld;
    int pDst, pM, pAcks, pBlk;
    for (int b = 0; b < NB; b++) begin
      mSt[b] = 0;
      mSh[b] = '0;
      for (int r = 0; r < NP; r++) begin
        ann[r][b] = 0; got[r][b] = 0; outInv[r][b] = 0; granted[r][b] = 0;
      end
    end
    mRspV = 0; mFwdMask = '0; mRspTag = "R2";
    mRspDst = 0; mRspM = 0; mRspAcks = 0; mRspBlk = 0;
    mFwdShare = 0; mFwdReq = 0; mFwdBlk = 0;
    prevWin = -1; prevHeld = 0;
    pDst = 0; pM = 0; pAcks = 0; pBlk = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(rspValid == 1'b0 && fwdValid == 1'b0 && reqReady == '0, "R1",
          $sformatf("reset outputs: actual rspV=%0d fwdV=%0d ready=%b expected 0 0 0000",
                    rspValid, fwdValid, reqReady));

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      bit busy;
      bit blockedBusy;
      int win;
      bit [NP-1:0] expReady;
      bit [NP-1:0] others [NP];
      bit need [NP];
      int blk [NP];
      string tag;

      @(negedge clk);
      if (prevWin >= 0) reqValid[prevWin] = 1'b0;
      rspReady = ($urandom % 4) != 0;
      fwdReady = ($urandom % 3) != 0;
      for (int p = 0; p < NP; p++) begin
        if (!reqValid[p] && ($urandom % 3) == 0) begin
          reqValid[p] = 1'b1;
          reqIsM[p] = ($urandom % 2) == 1;
          reqBlk[p*BW +: BW] = BW'((cyc < 2000) ? ($urandom % 3) : ($urandom % NB));
        end
      end
      #1;

      busy = (mFwdMask != 0);
      win = -1;
      blockedBusy = 0;
      for (int p = 0; p < NP; p++) begin
        bit elig;
        blk[p] = int'(reqBlk[p*BW +: BW]);
        others[p] = mSh[blk[p]] & ~(NP'(1) << p);
        need[p] = (others[p] != 0) && (reqIsM[p] || mSt[blk[p]] == 2);
        elig = reqValid[p] && !mRspV && !(busy && blk[p] == mFwdBlk) && !(need[p] && busy);
        if (reqValid[p] && !mRspV && busy && blk[p] == mFwdBlk) blockedBusy = 1;
        if (elig && win < 0) win = p;
      end
      expReady = '0;
      if (win >= 0) expReady[win] = 1'b1;
      tag = blockedBusy ? "R8" : "R9";
      check(reqReady == expReady, tag,
            $sformatf("reqReady actual=%b expected=%b", reqReady, expReady));

      check(rspValid == mRspV, mRspTag,
            $sformatf("rspValid actual=%0d expected=%0d", rspValid, mRspV));
      if (mRspV && rspValid) begin
        check(int'(rspDst) == mRspDst && int'(rspIsM) == mRspM &&
              int'(rspAcks) == mRspAcks && int'(rspBlk) == mRspBlk, mRspTag,
              $sformatf("rsp actual dst=%0d m=%0d acks=%0d blk=%0d expected dst=%0d m=%0d acks=%0d blk=%0d",
                        rspDst, rspIsM, rspAcks, rspBlk, mRspDst, mRspM, mRspAcks, mRspBlk));
      end
      if (prevHeld) begin
        check(rspValid && int'(rspDst) == pDst && int'(rspIsM) == pM &&
              int'(rspAcks) == pAcks && int'(rspBlk) == pBlk, "R10",
              $sformatf("held rsp actual v=%0d dst=%0d m=%0d acks=%0d blk=%0d expected v=1 dst=%0d m=%0d acks=%0d blk=%0d",
                        rspValid, rspDst, rspIsM, rspAcks, rspBlk, pDst, pM, pAcks, pBlk));
      end
      prevHeld = rspValid && !rspReady;
      pDst = int'(rspDst); pM = int'(rspIsM); pAcks = int'(rspAcks); pBlk = int'(rspBlk);

      tag = (mFwdShare != 0) ? "R3" : "R5";
      check(fwdValid == (mFwdMask != 0), tag,
            $sformatf("fwdValid actual=%0d expected=%0d", fwdValid, mFwdMask != 0));
      if (fwdValid && mFwdMask != 0) begin
        check(int'(fwdDst) == lowBit(mFwdMask) && int'(fwdShare) == mFwdShare &&
              int'(fwdReq) == mFwdReq && int'(fwdBlk) == mFwdBlk, tag,
              $sformatf("fwd actual dst=%0d share=%0d req=%0d blk=%0d expected dst=%0d share=%0d req=%0d blk=%0d",
                        fwdDst, fwdShare, fwdReq, fwdBlk, lowBit(mFwdMask), mFwdShare, mFwdReq, mFwdBlk));
      end

      // requestor-side view of delivered messages
      if (rspValid && rspReady && rspIsM) begin
        ann[rspDst][rspBlk] = int'(rspAcks);
        granted[rspDst][rspBlk] = 1;
      end
      if (fwdValid && fwdReady && !fwdShare) got[fwdReq][fwdBlk]++;
      if (mFwdMask != 0 && fwdReady && mFwdShare == 0) outInv[mFwdReq][mFwdBlk]--;
      for (int r = 0; r < NP; r++) begin
        for (int b = 0; b < NB; b++) begin
          if (granted[r][b] && outInv[r][b] == 0) begin
            check(got[r][b] == ann[r][b], "R7",
                  $sformatf("acks at port %0d block %0d actual=%0d expected=%0d",
                            r, b, got[r][b], ann[r][b]));
            granted[r][b] = 0;
            got[r][b] = 0;
            ann[r][b] = 0;
          end
        end
      end

      // model next state
      if (mFwdMask != 0 && fwdReady) mFwdMask[lowBit(mFwdMask)] = 1'b0;
      if (mRspV && rspReady) mRspV = 0;
      if (win >= 0) begin
        int b;
        b = blk[win];
        if (reqIsM[win]) begin
          mRspV = 1; mRspDst = win; mRspM = 1; mRspBlk = b;
          mRspAcks = popc(others[win]);
          mRspTag = (mRspAcks == 0) ? ((cyc < 40) ? "R1" : "R6") : "R4";
          if (need[win]) begin
            mFwdMask = others[win]; mFwdShare = 0; mFwdReq = win; mFwdBlk = b;
            outInv[win][b] = popc(others[win]);
          end
          mSt[b] = 2;
          mSh[b] = NP'(1) << win;
        end else begin
          if (need[win]) begin
            mFwdMask = others[win]; mFwdShare = 1; mFwdReq = win; mFwdBlk = b;
          end else begin
            mRspV = 1; mRspDst = win; mRspM = 0; mRspAcks = 0; mRspBlk = b;
            mRspTag = (mSt[b] == 2) ? "R11" : "R2";
          end
          mSt[b] = 1;
          mSh[b] = mSh[b] | (NP'(1) << win);
        end
      end
      prevWin = win;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule